// File: doc/BRIEF.md
# SMM I/O Trap Restart Controller

This block holds the small amount of state a processor core needs to enter and leave system management mode when a management interrupt cuts into an I/O instruction. When an SMI request is taken, the block raises its active flag and clears the 16-bit restart slot. It records whether a valid I/O instruction was trapped, closes NMI delivery, and captures the two debug control/status words. The handler may rewrite the restart slot. On the resume pulse the block decides whether the trapped instruction must be replayed, and it holds a replay request until the core acknowledges it.

A replay that is still waiting does not block a fresh SMI. The new entry is serviced first, marks no trapped instruction of its own, and the earlier replay request reappears after that second exit. Inside management mode, NMI stays closed until the first IRET completes, and after that it stays open until exit. On exit the NMI enable returns to its value before entry, and the captured debug words are offered back with a one-cycle restore strobe.

Top module: `smm_trap_ctl`

## Requirements
- R1: After reset, `smm_active`, `io_valid`, `slot_err`, `reexec_req` and `dbg_restore` are 0, `restart_slot` is 16'h0000, `nmi_en` is 1, and both debug save words are 0.
- R2: An `smi_req` sampled while `smm_active` is 0 sets `smm_active` at that edge and clears `restart_slot` to 16'h0000. An `smi_req` sampled while active has no effect.
- R3: At entry, `io_valid` takes the value of `io_trap_valid`, unless a replay is pending (see R7).
- R4: A `slot_wr` while active loads `slot_wdata` into `restart_slot`. A `slot_wr` while inactive leaves the slot unchanged.
- R5: An `rsm` while active clears `smm_active`. If the slot then holds 16'h00FF, `io_valid` is 1 and `slot_err` is 0, then `reexec_req` rises at that edge and stays high until a `replay_ack` is sampled with `smi_req` low.
- R6: An `rsm` with any other slot value raises no replay request.
- R7: An `smi_req` sampled while `reexec_req` is high wins over `replay_ack`. The nested entry has `io_valid` = 0 and hides the request while active. The request returns after the nested exit.
- R8: A `slot_wr` while active with `io_valid` = 0 sets `slot_err`. `slot_err` stays set until the next entry, and while it is set the exit raises no replay request.
- R9: An `rsm` while `smm_active` is 0 changes no output.
- R10: On entry `nmi_en` drops to 0. While active, `iret_done` sets it to 1, and an `nmi` taken while active does not clear it.
- R11: On exit `nmi_en` returns to its value before entry, even when `iret_done` arrives in the same cycle. While inactive, an `nmi` sampled with `nmi_en` = 1 clears it, and `iret_done` sets it; when both come together, `nmi` wins.
- R12: At entry `dbg_ctl_save`/`dbg_stat_save` capture `dbg_ctl_in`/`dbg_stat_in`. On exit `dbg_restore` pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smi_req | input | 1 | Pending management interrupt (level) |
| io_trap_valid | input | 1 | A valid I/O instruction was trapped by this SMI |
| slot_wr | input | 1 | Handler write strobe to the restart slot |
| slot_wdata | input | SLOT_W | Restart slot write data |
| rsm | input | 1 | Resume-from-SMM pulse |
| iret_done | input | 1 | IRET completion pulse |
| nmi | input | 1 | NMI being taken |
| replay_ack | input | 1 | Core has started the replay |
| dbg_ctl_in | input | DBG_W | Live debug control word |
| dbg_stat_in | input | DBG_W | Live debug status word |
| smm_active | output | 1 | Management mode is active |
| restart_slot | output | SLOT_W | Restart slot value |
| io_valid | output | 1 | Trapped I/O instruction valid bit |
| slot_err | output | 1 | Slot written while no valid trap |
| reexec_req | output | 1 | Replay trapped I/O instruction |
| nmi_en | output | 1 | NMI recognition enabled |
| dbg_ctl_save | output | DBG_W | Saved debug control word |
| dbg_stat_save | output | DBG_W | Saved debug status word |
| dbg_restore | output | 1 | One-cycle strobe to restore the debug words |

## Verification
Two pairs of events can land on the same edge. The first pair is a new SMI and the acknowledge of a pending replay. The bench drives `smi_req` and `replay_ack` together while `reexec_req` is high and expects entry with `io_valid` clear, the request hidden, and the request back after the nested exit. The second pair is the resume pulse and an IRET completion. The bench drives `rsm` and `iret_done` together with a closed pre-entry NMI state and expects `nmi_en` to return to 0 rather than open.

// File: rtl/smm_pkg.sv
// Package: shared constants for the SMM trap-restart controller.
// Assumes a 16-bit restart slot; the replay key is the low byte all ones.
package smm_pkg;
    localparam int SLOT_W_DEF = 16;
    localparam int DBG_W_DEF  = 32;
    localparam logic [SLOT_W_DEF-1:0] REPLAY_KEY_DEF = 16'h00FF;
endpackage

// File: rtl/smm_seq.sv
// Module: smm_seq
// Owns the SMM-active flag and the pending-replay flag and produces the
// entry and exit strobes used by the other submodules.
// Assumes smi_req is a level and rsm a single-cycle pulse.
module smm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_req,
    input  logic rsm,
    input  logic replay_ack,
    input  logic slot_hit,
    output logic enter_p,
    output logic exit_p,
    output logic active,
    output logic replay_pend
);
    // Entry and exit strobes from the current state.
    always_comb begin
        enter_p = smi_req && !active;
        exit_p  = rsm && active;
    end

    // Active flag: set on entry, cleared on exit.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (enter_p) active <= 1'b1;
        else if (exit_p)  active <= 1'b0;
    end

    // Replay flag: set by a qualifying exit, dropped by an acknowledge when no SMI is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            replay_pend <= 1'b0;
        else if (exit_p && slot_hit)
            replay_pend <= 1'b1;
        else if (replay_ack && !active && !smi_req)
            replay_pend <= 1'b0;
    end
endmodule

// File: rtl/smm_slot.sv
// Module: smm_slot
// Holds the restart slot, the trapped-I/O valid bit and the undefined-write
// error flag, and reports whether the slot requests a replay.
// Assumes enter_p and the write strobe come from the same clock domain.
module smm_slot #(
    parameter int                SLOT_W     = 16,
    parameter logic [SLOT_W-1:0] REPLAY_KEY = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_p,
    input  logic              active,
    input  logic              nested,
    input  logic              io_trap_valid,
    input  logic              slot_wr,
    input  logic [SLOT_W-1:0] slot_wdata,
    output logic [SLOT_W-1:0] slot,
    output logic              io_valid,
    output logic              slot_err,
    output logic              slot_hit
);
    // Slot register: cleared on entry, loaded by handler writes while active.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot <= '0;
        else if (enter_p)           slot <= '0;
        else if (slot_wr && active) slot <= slot_wdata;
    end

    // Valid bit: captured on entry; forced clear for a nested entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       io_valid <= 1'b0;
        else if (enter_p) io_valid <= io_trap_valid && !nested;
    end

    // Error flag: a write with no valid trap is undefined; cleared on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                              slot_err <= 1'b0;
        else if (enter_p)                        slot_err <= 1'b0;
        else if (slot_wr && active && !io_valid) slot_err <= 1'b1;
    end

    // Replay qualification seen by the sequencer at exit.
    always_comb slot_hit = (slot == REPLAY_KEY) && io_valid && !slot_err;
endmodule

// File: rtl/smm_nmi.sv
// Module: smm_nmi
// Tracks NMI recognition outside and inside SMM and saves/restores it
// across the SMM boundary.
// Assumes nmi means an NMI is being taken in this cycle.
module smm_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_p,
    input  logic exit_p,
    input  logic active,
    input  logic iret_done,
    input  logic nmi,
    output logic nmi_en
);
    logic saved_en;

    // Pre-entry copy of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       saved_en <= 1'b1;
        else if (enter_p) saved_en <= nmi_en;
    end

    // Enable: closed at entry, opened by IRET inside, restored at exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  nmi_en <= 1'b1;
        else if (enter_p)            nmi_en <= 1'b0;
        else if (exit_p)             nmi_en <= saved_en;
        else if (active) begin
            if (iret_done)           nmi_en <= 1'b1;
        end
        else if (nmi && nmi_en)      nmi_en <= 1'b0;
        else if (iret_done)          nmi_en <= 1'b1;
    end
endmodule

// File: rtl/smm_dbg_save.sv
// Module: smm_dbg_save
// Captures the debug control and status words at entry and strobes a
// restore request at exit.
// Assumes the core applies the saved words when it sees the strobe.
module smm_dbg_save #(
    parameter int DBG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_p,
    input  logic             exit_p,
    input  logic [DBG_W-1:0] ctl_in,
    input  logic [DBG_W-1:0] stat_in,
    output logic [DBG_W-1:0] ctl_save,
    output logic [DBG_W-1:0] stat_save,
    output logic             restore
);
    // Snapshot of both words on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_save  <= '0;
            stat_save <= '0;
        end else if (enter_p) begin
            ctl_save  <= ctl_in;
            stat_save <= stat_in;
        end
    end

    // One-cycle restore strobe following the exit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) restore <= 1'b0;
        else        restore <= exit_p;
    end
endmodule

// File: rtl/smm_trap_ctl.sv
// Module: smm_trap_ctl (top)
// Ties together the SMM sequencer, restart slot, NMI tracker and debug
// snapshot. The replay request is visible only outside SMM.
// Assumes all inputs are synchronous to clk.
module smm_trap_ctl #(
    parameter int                SLOT_W     = smm_pkg::SLOT_W_DEF,
    parameter int                DBG_W      = smm_pkg::DBG_W_DEF,
    parameter logic [SLOT_W-1:0] REPLAY_KEY = smm_pkg::REPLAY_KEY_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_req,
    input  logic              io_trap_valid,
    input  logic              slot_wr,
    input  logic [SLOT_W-1:0] slot_wdata,
    input  logic              rsm,
    input  logic              iret_done,
    input  logic              nmi,
    input  logic              replay_ack,
    input  logic [DBG_W-1:0]  dbg_ctl_in,
    input  logic [DBG_W-1:0]  dbg_stat_in,
    output logic              smm_active,
    output logic [SLOT_W-1:0] restart_slot,
    output logic              io_valid,
    output logic              slot_err,
    output logic              reexec_req,
    output logic              nmi_en,
    output logic [DBG_W-1:0]  dbg_ctl_save,
    output logic [DBG_W-1:0]  dbg_stat_save,
    output logic              dbg_restore
);
    logic enter_p, exit_p, replay_pend, slot_hit;

    smm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm(rsm),
        .replay_ack(replay_ack), .slot_hit(slot_hit),
        .enter_p(enter_p), .exit_p(exit_p),
        .active(smm_active), .replay_pend(replay_pend)
    );

    smm_slot #(.SLOT_W(SLOT_W), .REPLAY_KEY(REPLAY_KEY)) u_slot (
        .clk(clk), .rst_n(rst_n), .enter_p(enter_p), .active(smm_active),
        .nested(replay_pend), .io_trap_valid(io_trap_valid),
        .slot_wr(slot_wr), .slot_wdata(slot_wdata),
        .slot(restart_slot), .io_valid(io_valid),
        .slot_err(slot_err), .slot_hit(slot_hit)
    );

    smm_nmi u_nmi (
        .clk(clk), .rst_n(rst_n), .enter_p(enter_p), .exit_p(exit_p),
        .active(smm_active), .iret_done(iret_done), .nmi(nmi),
        .nmi_en(nmi_en)
    );

    smm_dbg_save #(.DBG_W(DBG_W)) u_dbg (
        .clk(clk), .rst_n(rst_n), .enter_p(enter_p), .exit_p(exit_p),
        .ctl_in(dbg_ctl_in), .stat_in(dbg_stat_in),
        .ctl_save(dbg_ctl_save), .stat_save(dbg_stat_save),
        .restore(dbg_restore)
    );

    // Replay request shown only while outside SMM.
    always_comb reexec_req = replay_pend && !smm_active;
endmodule

// File: rtl/smm_trap_ctl_chk.sv
// Module: smm_trap_ctl_chk
// Property checker bound to smm_trap_ctl; observes ports only.
module smm_trap_ctl_chk #(
    parameter int SLOT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smi_req,
    input logic              rsm,
    input logic              nmi,
    input logic              smm_active,
    input logic [SLOT_W-1:0] restart_slot,
    input logic              io_valid,
    input logic              slot_err,
    input logic              reexec_req,
    input logic              nmi_en,
    input logic              dbg_restore
);
    // R2: a fresh entry always shows a cleared slot.
    a_r2_entry_clears_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smm_active) |-> restart_slot == '0);

    // R10: NMI is closed in the first cycle of SMM.
    a_r10_nmi_closed_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smm_active) |-> !nmi_en);

    // R10: once open inside SMM, NMI stays open while SMM lasts.
    a_r10_nmi_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && nmi_en && !rsm && nmi) |=> nmi_en);

    // R5: a qualifying exit yields a replay request.
    a_r5_replay_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (smm_active && rsm && io_valid && !slot_err && restart_slot == 16'h00FF)
        |=> reexec_req);

    // R7: an entry taken over a waiting replay marks no trapped instruction.
    a_r7_nested_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(smm_active) && $past(reexec_req)) |-> !io_valid);

    // R9: a resume pulse outside SMM with no SMI leaves SMM inactive.
    a_r9_rsm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!smm_active && rsm && !smi_req) |=> (!smm_active && !dbg_restore));

    // R12: the restore strobe follows a cycle spent in SMM.
    a_r12_restore_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_restore |-> (!smm_active && $past(smm_active)));

    // R5: no replay request is visible inside SMM.
    a_r5_hidden_in_smm: assert property (@(posedge clk) disable iff (!rst_n)
        smm_active |-> !reexec_req);
endmodule

bind smm_trap_ctl smm_trap_ctl_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm(rsm), .nmi(nmi),
    .smm_active(smm_active), .restart_slot(restart_slot),
    .io_valid(io_valid), .slot_err(slot_err), .reexec_req(reexec_req),
    .nmi_en(nmi_en), .dbg_restore(dbg_restore)
);

// File: tb/sim_smm_trap_ctl.sv
// Scoreboard bench: the driver pushes the expected output set after each
// edge, the monitor pops it at the next falling edge and compares.
module sim_smm_trap_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_req = 0, io_trap_valid = 0, slot_wr = 0, rsm = 0;
    logic iret_done = 0, nmi = 0, replay_ack = 0;
    logic [15:0] slot_wdata = '0;
    logic [31:0] dbg_ctl_in = 32'h0000_0400, dbg_stat_in = 32'hFFFF_0FF0;
    logic smm_active, io_valid, slot_err, reexec_req, nmi_en, dbg_restore;
    logic [15:0] restart_slot;
    logic [31:0] dbg_ctl_save, dbg_stat_save;

    typedef struct {
        string       tag;
        logic        act;
        logic [15:0] slot;
        logic        iov;
        logic        err;
        logic        rex;
        logic        nen;
        logic [31:0] dctl;
        logic [31:0] dstat;
        logic        drst;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smm_trap_ctl u0 (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .io_trap_valid(io_trap_valid),
        .slot_wr(slot_wr), .slot_wdata(slot_wdata), .rsm(rsm),
        .iret_done(iret_done), .nmi(nmi), .replay_ack(replay_ack),
        .dbg_ctl_in(dbg_ctl_in), .dbg_stat_in(dbg_stat_in),
        .smm_active(smm_active), .restart_slot(restart_slot), .io_valid(io_valid),
        .slot_err(slot_err), .reexec_req(reexec_req), .nmi_en(nmi_en),
        .dbg_ctl_save(dbg_ctl_save), .dbg_stat_save(dbg_stat_save),
        .dbg_restore(dbg_restore)
    );

    // Driver: one clock with the current inputs, then push the expectation.
    task automatic step(input string tag);
        @(posedge clk);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        smi_req = 0; io_trap_valid = 0; slot_wr = 0; rsm = 0;
        iret_done = 0; nmi = 0; replay_ack = 0;
        e.drst = 0;
    endtask

    task automatic cmp1(input string tag, input string f, input logic [31:0] a, input logic [31:0] x);
        n_cmp++;
        if (a !== x) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, f, a, x);
        end
    endtask

    // Monitor: pop and compare at the falling edge after the push.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            cmp1(x.tag, "smm_active", 32'(smm_active), 32'(x.act));
            cmp1(x.tag, "restart_slot", 32'(restart_slot), 32'(x.slot));
            cmp1(x.tag, "io_valid", 32'(io_valid), 32'(x.iov));
            cmp1(x.tag, "slot_err", 32'(slot_err), 32'(x.err));
            cmp1(x.tag, "reexec_req", 32'(reexec_req), 32'(x.rex));
            cmp1(x.tag, "nmi_en", 32'(nmi_en), 32'(x.nen));
            cmp1(x.tag, "dbg_ctl_save", dbg_ctl_save, x.dctl);
            cmp1(x.tag, "dbg_stat_save", dbg_stat_save, x.dstat);
            cmp1(x.tag, "dbg_restore", 32'(dbg_restore), 32'(x.drst));
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        e = '{tag:"", act:0, slot:16'h0, iov:0, err:0, rex:0, nen:1, dctl:0, dstat:0, drst:0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1 reset state");

        // R2 R3 R10 R12: entry with a valid trap
        smi_req = 1; io_trap_valid = 1;
        e.act = 1; e.slot = 0; e.iov = 1; e.nen = 0;
        e.dctl = dbg_ctl_in; e.dstat = dbg_stat_in;
        step("R2 R3 R12 entry");
        // R2: SMI while active has no effect
        smi_req = 1; step("R2 smi while active");
        // R4: handler writes key
        slot_wr = 1; slot_wdata = 16'h00FF; e.slot = 16'h00FF; step("R4 slot write");
        // R10: IRET opens NMI
        iret_done = 1; e.nen = 1; step("R10 iret opens nmi");
        nmi = 1; step("R10 nmi inside keeps open");
        // R5 R11 R12: exit with replay
        rsm = 1; e.act = 0; e.rex = 1; e.nen = 1; e.drst = 1; step("R5 R11 exit replay");
        step("R5 R12 request held, strobe gone");

        // R7: SMI and acknowledge together; SMI wins
        smi_req = 1; io_trap_valid = 1; replay_ack = 1;
        e.act = 1; e.slot = 0; e.iov = 0; e.rex = 0; e.nen = 0;
        step("R7 nested entry over replay");
        rsm = 1; e.act = 0; e.rex = 1; e.nen = 1; e.drst = 1; step("R7 replay back after nested exit");
        replay_ack = 1; e.rex = 0; step("R5 replay ack");

        // R11: NMI outside masks
        nmi = 1; e.nen = 0; step("R11 nmi outside masks");
        // R3: entry without a valid trap, new debug words
        dbg_ctl_in = 32'h0000_0155; dbg_stat_in = 32'h0000_4001;
        smi_req = 1; io_trap_valid = 0;
        e.act = 1; e.slot = 0; e.iov = 0; e.nen = 0;
        e.dctl = 32'h0000_0155; e.dstat = 32'h0000_4001;
        step("R3 R12 entry without trap");
        // R8: undefined write
        slot_wr = 1; slot_wdata = 16'h00FF; e.slot = 16'h00FF; e.err = 1; step("R8 write with no valid trap");
        rsm = 1; e.act = 0; e.rex = 0; e.nen = 0; e.drst = 1; step("R8 R11 exit no replay, nmi restored closed");
        // R9: resume while idle
        rsm = 1; step("R9 rsm while idle");
        // R4: write while idle ignored
        slot_wr = 1; slot_wdata = 16'hABCD; step("R4 write while idle");
        // R11: IRET outside opens; NMI and IRET together -> masked
        iret_done = 1; e.nen = 1; step("R11 iret outside");
        nmi = 1; iret_done = 1; e.nen = 0; step("R11 nmi beats iret outside");
        iret_done = 1; e.nen = 1; step("R11 iret outside reopens");

        // R6: other slot value
        smi_req = 1; io_trap_valid = 1;
        e.act = 1; e.slot = 0; e.iov = 1; e.err = 0; e.nen = 0;
        step("R8 R2 entry clears error");
        slot_wr = 1; slot_wdata = 16'h1234; e.slot = 16'h1234; step("R6 non-key write");
        rsm = 1; e.act = 0; e.rex = 0; e.nen = 1; e.drst = 1; step("R6 exit no replay");

        // R11: resume and IRET together with a closed pre-entry state
        nmi = 1; e.nen = 0; step("R11 mask before entry");
        smi_req = 1; io_trap_valid = 1;
        e.act = 1; e.slot = 0; e.iov = 1; step("R3 entry");
        slot_wr = 1; slot_wdata = 16'h00FF; e.slot = 16'h00FF; step("R4 key write");
        rsm = 1; iret_done = 1; e.act = 0; e.rex = 1; e.nen = 0; e.drst = 1;
        step("R11 rsm beats iret");
        replay_ack = 1; e.rex = 0; step("R5 ack clears");

        @(negedge clk);
        finish_run();
    end
endmodule